// File: doc/BRIEF.md
# Streaming-Multiprocessor Cluster Grouping Controller

This controller decides, kernel by kernel, whether groups of neighbouring streaming multiprocessors share one instruction front end. The SMs are split into fixed clusters of `CLUSTER` adjacent units (2 or 4). When a kernel starts, every cluster whose members are all active becomes a shared group. Its lowest-numbered member leads and fetches for everyone. The other members follow in lock-step, with their own front ends gated off.

Each cycle the controller compares the next-instruction addresses that the members of a shared group report. If two valid addresses differ, that group is broken up and every member runs on its own front end. A group that has been broken up stays apart until the kernel-end strobe. The next kernel-launch strobe gives every cluster a fresh chance to form a group.

Top module: `sm_group_ctrl`

## Requirements
- R1: After synchronous reset, and before the first launch, `lead_o`, `follow_o`, `shared_o` and `fe_off_o` are all zero.
- R2: On the clock edge that samples `kern_start_i` high, a cluster whose members all have `sm_active_i` high becomes shared. From the next cycle, `shared_o` is 1 for each member, `lead_o` is 1 only for the member with the lowest index (bit `c*CLUSTER`), and `follow_o` is 1 for the other members.
- R3: `fe_off_o` of an SM is 1 exactly when that SM is a follower of a shared cluster. A leader's front end is never switched off.
- R4: If any member of a cluster has `sm_active_i` low at launch, that cluster is not shared for the kernel, and all four outputs stay 0 for its members.
- R5: In a shared cluster, two members with `nxt_vld_i` high and different `nxt_pc_i` values in the same cycle break the group. From the next cycle, the member bits of all four outputs are 0. An address whose valid bit is 0 does not take part in the comparison, and equal valid addresses leave the group intact.
- R6: A broken-up cluster stays independent until the kernel ends, even after the member addresses agree again.
- R7: A cycle with `kern_end_i` high, and `kern_start_i` low, returns every cluster to independent operation on the next cycle.
- R8: A cluster that was broken up in one kernel groups again at the next launch if all its members are active.
- R9: Breaking up one cluster leaves the outputs of the other clusters unchanged.
- R10: `kern_start_i` takes priority. If it is high in the same cycle as a divergence or as `kern_end_i`, each eligible cluster is shared on the next cycle.
- R11: Bit `i` of `nxt_vld_i` goes with `nxt_pc_i[i*PC_W +: PC_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kern_start_i | input | 1 | Kernel-launch strobe, one cycle |
| kern_end_i | input | 1 | Kernel-end strobe, one cycle |
| sm_active_i | input | NUM_SM | SM-active mask, sampled at launch |
| nxt_vld_i | input | NUM_SM | Per-SM next-instruction address valid |
| nxt_pc_i | input | NUM_SM*PC_W | Per-SM next-instruction addresses, SM i in slice i |
| lead_o | output | NUM_SM | SM leads a shared cluster |
| follow_o | output | NUM_SM | SM follows its cluster's leader |
| shared_o | output | NUM_SM | SM belongs to a shared cluster |
| fe_off_o | output | NUM_SM | Gate request for the SM's front end |

## Verification
A divergence can arrive in the same cycle as a launch strobe, and it can also arrive with an end strobe. The bench provokes both cases. It first breaks the group of cluster 0 with `kern_start_i` high in that cycle, and checks that the cluster is shared on the next cycle instead of split. It then raises launch and end together and checks that the launch wins. A divergence that comes with only an end strobe has to leave the clusters independent.

// File: rtl/smgrp_pkg.sv
package smgrp_pkg;

    typedef enum logic [1:0] {
        CL_IDLE   = 2'd0,
        CL_SHARED = 2'd1,
        CL_SPLIT  = 2'd2
    } cl_state_e;

    typedef struct packed {
        logic lead;
        logic follow;
        logic shared;
        logic fe_off;
    } sm_role_t;

    function automatic cl_state_e next_state(
        input cl_state_e cur,
        input logic      start,
        input logic      stop,
        input logic      all_active,
        input logic      diverged
    );
        cl_state_e nxt;
        nxt = cur;
        if (start) begin
            nxt = all_active ? CL_SHARED : CL_SPLIT;
        end else if (stop) begin
            nxt = CL_IDLE;
        end else if (cur == CL_SHARED && diverged) begin
            nxt = CL_SPLIT;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/smgrp_div_detect.sv
module smgrp_div_detect #(
    parameter int N    = 4,
    parameter int PC_W = 32
) (
    input  logic [N-1:0]      vld_i,
    input  logic [N*PC_W-1:0] pc_i,
    output logic              div_o
);
    always_comb begin
        div_o = 1'b0;
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                if (vld_i[a] && vld_i[b] &&
                    (pc_i[a*PC_W +: PC_W] != pc_i[b*PC_W +: PC_W])) begin
                    div_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/smgrp_cl_fsm.sv
module smgrp_cl_fsm
    import smgrp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      all_active_i,
    input  logic      div_i,
    output cl_state_e state_o
);
    cl_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= CL_IDLE;
        else     state_q <= next_state(state_q, start_i, stop_i, all_active_i, div_i);
    end

    assign state_o = state_q;

    assert_launch_groups_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && all_active_i) |=> (state_q == CL_SHARED));
    assert_inactive_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !all_active_i) |=> (state_q != CL_SHARED));
    assert_diverge_splits_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == CL_SHARED && div_i && !start_i && !stop_i) |=> (state_q == CL_SPLIT));
    assert_split_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q != CL_SHARED && !start_i) |=> (state_q != CL_SHARED));
    assert_end_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i) |=> (state_q == CL_IDLE));
endmodule

// File: rtl/smgrp_role_map.sv
module smgrp_role_map
    import smgrp_pkg::*;
#(
    parameter int N = 4
) (
    input  cl_state_e      state_i,
    output logic [N-1:0]   lead_o,
    output logic [N-1:0]   follow_o,
    output logic [N-1:0]   shared_o,
    output logic [N-1:0]   fe_off_o
);
    sm_role_t role [N];

    for (genvar m = 0; m < N; m++) begin : g_member
        always_comb begin
            role[m].shared = (state_i == CL_SHARED);
            role[m].lead   = role[m].shared && (m == 0);
            role[m].follow = role[m].shared && (m != 0);
            role[m].fe_off = role[m].follow;
        end
        assign lead_o[m]   = role[m].lead;
        assign follow_o[m] = role[m].follow;
        assign shared_o[m] = role[m].shared;
        assign fe_off_o[m] = role[m].fe_off;
    end
endmodule

// File: rtl/sm_group_ctrl.sv
module sm_group_ctrl
    import smgrp_pkg::*;
#(
    parameter int NUM_SM  = 16,
    parameter int CLUSTER = 4,
    parameter int PC_W    = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   kern_start_i,
    input  logic                   kern_end_i,
    input  logic [NUM_SM-1:0]      sm_active_i,
    input  logic [NUM_SM-1:0]      nxt_vld_i,
    input  logic [NUM_SM*PC_W-1:0] nxt_pc_i,
    output logic [NUM_SM-1:0]      lead_o,
    output logic [NUM_SM-1:0]      follow_o,
    output logic [NUM_SM-1:0]      shared_o,
    output logic [NUM_SM-1:0]      fe_off_o
);
    localparam int NUM_CL = NUM_SM / CLUSTER;
    localparam int SLICE  = CLUSTER * PC_W;

    for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
        logic      div;
        logic      all_act;
        cl_state_e st;

        assign all_act = &sm_active_i[c*CLUSTER +: CLUSTER];

        smgrp_div_detect #(.N(CLUSTER), .PC_W(PC_W)) u_div (
            .vld_i (nxt_vld_i[c*CLUSTER +: CLUSTER]),
            .pc_i  (nxt_pc_i[c*SLICE +: SLICE]),
            .div_o (div)
        );

        smgrp_cl_fsm u_fsm (
            .clk          (clk),
            .rst          (rst),
            .start_i      (kern_start_i),
            .stop_i       (kern_end_i),
            .all_active_i (all_act),
            .div_i        (div),
            .state_o      (st)
        );

        smgrp_role_map #(.N(CLUSTER)) u_map (
            .state_i  (st),
            .lead_o   (lead_o[c*CLUSTER +: CLUSTER]),
            .follow_o (follow_o[c*CLUSTER +: CLUSTER]),
            .shared_o (shared_o[c*CLUSTER +: CLUSTER]),
            .fe_off_o (fe_off_o[c*CLUSTER +: CLUSTER])
        );

        assert_one_lead_R2: assert property (@(posedge clk) disable iff (rst)
            $onehot0(lead_o[c*CLUSTER +: CLUSTER]));
        assert_gate_not_lead_R3: assert property (@(posedge clk) disable iff (rst)
            ((fe_off_o[c*CLUSTER +: CLUSTER] & lead_o[c*CLUSTER +: CLUSTER]) == '0));
        assert_gate_needs_share_R3: assert property (@(posedge clk) disable iff (rst)
            ((fe_off_o[c*CLUSTER +: CLUSTER] & ~shared_o[c*CLUSTER +: CLUSTER]) == '0));
    end

    initial begin
        assert_cluster_size_R2: assert ((CLUSTER == 2 || CLUSTER == 4) &&
                                        (NUM_SM % CLUSTER == 0))
            else $error("CLUSTER must be 2 or 4 and must divide NUM_SM");
    end
endmodule

// File: tb/sm_group_ctrl_bench.sv
module sm_group_ctrl_bench;
    localparam int N  = 16;
    localparam int CL = 4;
    localparam int W  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, stop = 1'b0;
    logic [N-1:0] act = '1;
    logic [N-1:0] vld = '1;
    logic [31:0]  pc [N];
    logic [N*W-1:0] pc_flat;
    logic [N-1:0] lead, follow, shared, fe_off;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) pc_flat[i*W +: W] = pc[i];
    end

    sm_group_ctrl #(.NUM_SM(N), .CLUSTER(CL), .PC_W(W)) u_sm_group_ctrl (
        .clk(clk), .rst(rst), .kern_start_i(start), .kern_end_i(stop),
        .sm_active_i(act), .nxt_vld_i(vld), .nxt_pc_i(pc_flat),
        .lead_o(lead), .follow_o(follow), .shared_o(shared), .fe_off_o(fe_off)
    );

    function automatic logic [N-1:0] exp_lead(input logic [N/CL-1:0] grp);
        logic [N-1:0] v = '0;
        for (int c = 0; c < N/CL; c++) if (grp[c]) v[c*CL] = 1'b1;
        return v;
    endfunction

    function automatic logic [N-1:0] exp_shared(input logic [N/CL-1:0] grp);
        logic [N-1:0] v = '0;
        for (int c = 0; c < N/CL; c++) if (grp[c]) v[c*CL +: CL] = '1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act_v, input logic [N-1:0] exp_v);
        tests++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act_v, exp_v);
        end
    endtask

    task automatic chk_all(input string req, input logic [N/CL-1:0] grp);
        chk({req, " lead"},   lead,   exp_lead(grp));
        chk({req, " shared"}, shared, exp_shared(grp));
        chk({req, " follow"}, follow, exp_shared(grp) & ~exp_lead(grp));
        chk({req, " fe_off R3"}, fe_off, exp_shared(grp) & ~exp_lead(grp));
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic launch();
        start = 1'b1; step(); start = 1'b0;
    endtask

    task automatic t_reset();
        chk_all("R1 reset", 4'b0000);
    endtask

    task automatic t_group();
        launch();
        chk_all("R2 launch", 4'b1111);
        vld[1] = 1'b0; pc[1] = 32'hdead; step();
        chk_all("R5 invalid ignored", 4'b1111);
        for (int i = 0; i < N; i++) pc[i] = 32'h100;
        step();
        chk_all("R5 equal kept", 4'b1111);
        vld[1] = 1'b1; pc[1] = 32'h100;
    endtask

    task automatic t_diverge();
        pc[6] = 32'h200; step();
        chk_all("R5 R9 split c1", 4'b1101);
        pc[6] = 32'h100; step(); step();
        chk_all("R6 stays split", 4'b1101);
    endtask

    task automatic t_end();
        stop = 1'b1; step(); stop = 1'b0;
        chk_all("R7 end", 4'b0000);
        pc[2] = 32'h300; step();
        chk_all("R7 idle no diverge", 4'b0000);
        pc[2] = 32'h100;
    endtask

    task automatic t_inactive();
        act[10] = 1'b0; launch();
        chk_all("R4 R8 inactive c2", 4'b1011);
        act[10] = 1'b1;
        stop = 1'b1; step(); stop = 1'b0;
    endtask

    task automatic t_collide();
        launch();
        pc[3] = 32'h400; start = 1'b1; step(); start = 1'b0;
        chk_all("R10 launch beats diverge", 4'b1111);
        step();
        chk_all("R5 diverge after", 4'b1110);
        pc[3] = 32'h100;
        start = 1'b1; stop = 1'b1; step(); start = 1'b0; stop = 1'b0;
        chk_all("R10 launch beats end", 4'b1111);
        pc[14] = 32'h500; stop = 1'b1; step(); stop = 1'b0;
        chk_all("R7 end with diverge", 4'b0000);
        pc[14] = 32'h100;
    endtask

    task automatic t_pairing();
        launch();
        vld = '0; vld[8] = 1'b1; vld[11] = 1'b1; pc[11] = 32'h600; step();
        chk_all("R11 lane pairing", 4'b1011);
        vld = '1; pc[11] = 32'h100;
    endtask

    initial begin
        for (int i = 0; i < N; i++) pc[i] = 32'h100;
        step(); step(); rst = 1'b0; step();
        t_reset();
        t_group();
        t_diverge();
        t_end();
        t_inactive();
        t_collide();
        t_pairing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (5000) @(posedge clk); end
        join_any
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule